// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line. It runs from a sample-enable pulse at sixteen times the bit rate. A separate divider produces that pulse from the system clock. The line passes through a two-flop synchroniser. While the receiver is idle, the first enable pulse that sees the line low marks the start of a frame. From that point a four-bit phase counter samples every bit on the eighth enable pulse of the bit, which is mid-bit. The start bit is sampled again at its mid-point, and a start bit that has returned high is dropped as a glitch. The frame is eight data bits sent least significant bit first, an optional even or odd parity bit, and one stop bit.

A completed frame loads a byte register and sets a full flag. Overrun, parity and framing errors are sticky flags, and each has its own clear strobe. The synchronised line level is exposed, so that software can tell a line held low (a break) from a single bad frame. During a break the receiver keeps collecting all-zero frames, so the framing error sets again after software clears it. Dropping the receive enable stops reception but leaves every flag as it was.

The state machine has five states:
- `RX_IDLE` waits for a low line.
- `RX_START` checks the start bit at mid-bit. It goes back to `RX_IDLE` on a glitch and goes on to `RX_DATA` on a valid low.
- `RX_DATA` shifts in eight bits and then moves to `RX_PAR` when parity is enabled, or to `RX_STOP` when it is not.
- `RX_PAR` captures the parity bit and moves to `RX_STOP`.
- `RX_STOP` samples the stop bit, reports the frame and returns to `RX_IDLE`.

From every state, `rx_en` low forces `RX_IDLE`.

Top module: `uart_os_rx`

## Requirements
- R1: State changes and bit sampling happen only on clock edges where `tick` is high, with 16 `tick` pulses per bit. The start of a frame is the first `tick` in idle at which the synchronised line is low. Each bit is sampled on the 8th `tick` after its start.
- R2: The start bit is sampled again at its mid-point. If the line is high there, the frame is dropped, the receiver returns to idle and `rx_full` stays 0.
- R3: Eight data bits are received least significant bit first. The clock edge after the stop-bit sample loads `rx_data` and sets `rx_full`.
- R4: When `par_en`=1 a parity bit follows the data. With `par_odd`=0 the data plus the parity bit must hold an even number of ones; with `par_odd`=1 they must hold an odd number. A mismatch sets `par_err`. When `par_en`=0 there is no parity bit and `par_err` is never set.
- R5: A stop bit sampled low sets `frm_err`, and the byte is still stored.
- R6: A frame that completes while `rx_full`=1 sets `ovr_err` and leaves `rx_data`, `par_err` and `frm_err` unchanged.
- R7: `rd_ack` clears `rx_full`. `clr_ovr`, `clr_par` and `clr_frm` each clear their own flag. A flag being set in the same cycle wins over its clear.
- R8: When `rx_en`=0 the receiver is held idle and frames on the line are ignored (`rx_full` stays 0). `ovr_err`, `par_err` and `frm_err` keep their values.
- R9: Under a continuous break, the receiver keeps receiving all-zero frames, so `frm_err` sets again after it has been cleared.
- R10: `rxd_level` follows `rxd` after two clock edges.
- R11: After reset, `rx_full`, `ovr_err`, `par_err` and `frm_err` are 0, `rx_data` is 0 and `rxd_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample enable, 16 pulses per bit |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial input line, idle high |
| rd_ack | input | 1 | Strobe: byte consumed, clears `rx_full` |
| clr_ovr | input | 1 | Strobe: clear the overrun flag |
| clr_par | input | 1 | Strobe: clear the parity flag |
| clr_frm | input | 1 | Strobe: clear the framing flag |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Byte waiting to be read |
| ovr_err | output | 1 | Overrun error, sticky |
| par_err | output | 1 | Parity error, sticky |
| frm_err | output | 1 | Framing error, sticky |
| rxd_level | output | 1 | Synchronised line level |

## Verification
On every cycle, the assertions check four things:
- A frame is reported only on a sample pulse.
- A high line at the start-bit mid-point sends the machine back to idle, and `rx_en` low forces idle.
- An overrun keeps the stored byte.
- The flags stay set until cleared, and `rd_ack` empties the buffer.

Only the bench scenarios can show the rest: the bit order and parity arithmetic on real frames, framing errors that come back again and again during a long break, flags that survive a disabled receiver, and frames that are ignored while the receiver is disabled.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd_s,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    rx_state_e         state, state_n;
    logic [CNT_W-1:0]  phase;
    logic [BIT_W-1:0]  bit_idx;
    logic              pbit;
    logic              mid;

    assign mid = (phase == MID);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        if (!rx_en) begin
            state_n = RX_IDLE;
        end else if (tick) begin
            unique case (state)
                RX_IDLE:  if (!rxd_s) state_n = RX_START;
                RX_START: if (mid) state_n = rxd_s ? RX_IDLE : RX_DATA;
                RX_DATA:  if (mid && bit_idx == LAST)
                              state_n = par_en ? RX_PAR : RX_STOP;
                RX_PAR:   if (mid) state_n = RX_STOP;
                RX_STOP:  if (mid) state_n = RX_IDLE;
                default:  state_n = RX_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_idx <= '0;
            data    <= '0;
            pbit    <= 1'b0;
            done    <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                phase   <= '0;
                bit_idx <= '0;
            end else if (tick) begin
                if (state == RX_IDLE) begin
                    phase   <= '0;
                    bit_idx <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
                if (mid) begin
                    unique case (state)
                        RX_DATA: begin
                            data    <= {rxd_s, data[DATA_W-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                        end
                        RX_PAR:  pbit <= rxd_s;
                        RX_STOP: begin
                            done <= 1'b1;
                            ferr <= !rxd_s;
                            perr <= par_en && ((^data ^ pbit) != par_odd);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    p_done_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick));
    p_glitch_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && tick && state == RX_START && mid && rxd_s) |=> state == RX_IDLE);
    p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == RX_IDLE);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
    parameter int DATA_W    = 8,
    parameter int OSR       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    input  logic              rd_ack,
    input  logic              clr_ovr,
    input  logic              clr_par,
    input  logic              clr_frm,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              ovr_err,
    output logic              par_err,
    output logic              frm_err,
    output logic              rxd_level
);
    logic              rxd_s;
    logic              done;
    logic [DATA_W-1:0] fr_data;
    logic              fr_perr;
    logic              fr_ferr;

    uart_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    uart_rx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .rxd_s(rxd_s),
        .done(done), .data(fr_data), .perr(fr_perr), .ferr(fr_ferr)
    );

    assign rxd_level = rxd_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            ovr_err <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            if (done && !rx_full) begin
                rx_data <= fr_data;
                rx_full <= 1'b1;
            end else if (rd_ack) begin
                rx_full <= 1'b0;
            end

            if (done && rx_full)             ovr_err <= 1'b1;
            else if (clr_ovr)                ovr_err <= 1'b0;

            if (done && !rx_full && fr_perr) par_err <= 1'b1;
            else if (clr_par)                par_err <= 1'b0;

            if (done && !rx_full && fr_ferr) frm_err <= 1'b1;
            else if (clr_frm)                frm_err <= 1'b0;
        end
    end

    p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full) |=> (ovr_err && $stable(rx_data)));
    p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !done) |=> !rx_full);
    p_frm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err && !clr_frm) |=> frm_err);
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !clr_ovr) |=> ovr_err);
endmodule

// File: tb/uart_os_rx_test.sv
`timescale 1ns/1ps
module uart_os_rx_test;
    localparam int BIT_CLKS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxd = 1'b1;
    logic       mon_ack = 1'b0;
    logic       man_ack = 1'b0;
    logic       man_clr = 1'b0;
    logic       rd_ack;
    logic       clr_ovr, clr_par, clr_frm;
    logic [7:0] rx_data;
    logic       rx_full, ovr_err, par_err, frm_err, rxd_level;
    logic       mon_en = 1'b0;
    logic [1:0] tdiv = '0;

    int checks = 0;
    int fails  = 0;
    logic [9:0] expq[$];

    assign rd_ack  = mon_ack | man_ack;
    assign clr_ovr = man_clr;
    assign clr_par = mon_ack | man_clr;
    assign clr_frm = mon_ack | man_clr;

    uart_os_rx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
        .rd_ack(rd_ack), .clr_ovr(clr_ovr), .clr_par(clr_par), .clr_frm(clr_frm),
        .rx_data(rx_data), .rx_full(rx_full), .ovr_err(ovr_err),
        .par_err(par_err), .frm_err(frm_err), .rxd_level(rxd_level)
    );

    always #2 clk = ~clk;

    // R1: one tick every four clocks, 16 ticks per bit
    initial forever begin
        @(negedge clk);
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input int n);
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    // driver: sends one frame, optionally pushes the expected result
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v, input bit push);
        logic pb;
        pb = (^d) ^ par_odd ^ bad_par;
        if (push) expq.push_back({~stop_v, par_en & bad_par, d});
        rxd = 1'b0; bit_time(1);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; bit_time(1); end
        if (par_en) begin rxd = pb; bit_time(1); end
        rxd = stop_v; bit_time(1);
        rxd = 1'b1; bit_time(1);
    endtask

    task automatic man_pulse(input bit ack, input bit clr);
        @(negedge clk);
        man_ack = ack; man_clr = clr;
        @(negedge clk);
        man_ack = 1'b0; man_clr = 1'b0;
    endtask

    task automatic wait_full(input int limit);
        int n = 0;
        while (!rx_full && n < limit) begin @(negedge clk); n++; end
    endtask

    // monitor: pops expected items and compares
    initial forever begin
        @(negedge clk);
        mon_ack = 1'b0;
        if (mon_en && rx_full) begin
            if (expq.size() == 0) begin
                check("R2/R3 unexpected byte", 32'(rx_data), 32'hFFFF);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                check("R3 data", 32'(rx_data), 32'(e[7:0]));
                check("R4 par_err", 32'(par_err), 32'(e[8]));
                check("R5 frm_err", 32'(frm_err), 32'(e[9]));
                check("R6 no overrun", 32'(ovr_err), 32'h0);
            end
            mon_ack = 1'b1;
        end
    end

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        check("R11 rx_full", 32'(rx_full), 0);
        check("R11 flags", 32'({ovr_err, par_err, frm_err}), 0);
        check("R11 rx_data", 32'(rx_data), 0);
        check("R11 rxd_level", 32'(rxd_level), 1);
        rst_n = 1'b1;
        rx_en = 1'b1;
        mon_en = 1'b1;
        bit_time(1);

        // R3 / R1: plain frames
        send_frame(8'hA5, 0, 1, 1);
        send_frame(8'h01, 0, 1, 1);
        send_frame(8'h80, 0, 1, 1);
        // R4 parity even and odd, good and bad
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h37, 0, 1, 1);
        send_frame(8'h37, 1, 1, 1);
        par_odd = 1'b1;
        send_frame(8'hC4, 0, 1, 1);
        send_frame(8'hC4, 1, 1, 1);
        par_en = 1'b0;
        // R5 bad stop bit
        send_frame(8'h5A, 0, 0, 1);
        bit_time(2);
        check("R3 queue drained", 32'(expq.size()), 0);

        // R2 glitch: low for 5 ticks only
        rxd = 1'b0; repeat (20) @(negedge clk);
        rxd = 1'b1; bit_time(12);
        check("R2 glitch dropped", 32'(rx_full), 0);
        mon_en = 1'b0;

        // R10 synchroniser delay
        @(negedge clk); rxd = 1'b0;
        @(negedge clk); check("R10 level after 1", 32'(rxd_level), 1);
        @(negedge clk); check("R10 level after 2", 32'(rxd_level), 0);
        rxd = 1'b1; bit_time(12);
        man_pulse(1, 1);

        // R6 overrun
        send_frame(8'h3C, 0, 1, 0);
        send_frame(8'hC3, 0, 1, 0);
        check("R6 ovr_err", 32'(ovr_err), 1);
        check("R6 data kept", 32'(rx_data), 32'h3C);
        man_pulse(1, 1);
        check("R7 ovr cleared", 32'(ovr_err), 0);
        check("R7 full cleared", 32'(rx_full), 0);

        // R9 continuous break
        rxd = 1'b0;
        wait_full(15 * BIT_CLKS);
        check("R9 first break frame", 32'(rx_full), 1);
        check("R9 first frm_err", 32'(frm_err), 1);
        check("R9 break data", 32'(rx_data), 0);
        check("R10 break level", 32'(rxd_level), 0);
        man_pulse(1, 1);
        check("R7 frm cleared", 32'(frm_err), 0);
        wait_full(15 * BIT_CLKS);
        check("R9 frm_err again", 32'(frm_err), 1);

        // R8: disable keeps flags, ignores frames
        rx_en = 1'b0;
        rxd = 1'b1;
        man_pulse(1, 0);
        bit_time(2);
        check("R8 frm kept", 32'(frm_err), 1);
        send_frame(8'h99, 0, 1, 0);
        check("R8 frame ignored", 32'(rx_full), 0);
        check("R8 frm still", 32'(frm_err), 1);
        rx_en = 1'b1;
        man_pulse(1, 1);
        check("R7 all clear", 32'({rx_full, ovr_err, par_err, frm_err}), 0);

        mon_en = 1'b1;
        send_frame(8'h6E, 0, 1, 1);
        bit_time(1);
        check("R3 final drained", 32'(expq.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule